// File: doc/BRIEF.md
# Volume Envelope Generator

This block keeps a 4-bit loudness level and moves it by one step each time a long programmable countdown runs out. It can climb toward 15 or fall toward 0. When the level is already at the end it is heading for, it holds there. If the wrap option is set, it jumps back to a programmed start value instead. A one-cycle start strobe loads the start value and restarts the countdown. This lets software start a note with a known level and a known time to the first step.

The countdown period is (interval + 1) × TICK_UNIT system clocks. TICK_UNIT defaults to 307220, and the interval field is 3 bits. The countdown advances only while the enable input is high, so clearing the enable freezes both the level and the countdown. The level output drives a later volume stage that is outside this block.

Top module: `vol_env_gen`

## Requirements
- R1: After reset the level output is 0 and the countdown is zero, so the first enabled cycle with no start strobe counts as an expiry.
- R2: A start strobe (`env_start` high at a clock edge) sets the level to `env_reload` at that edge. This happens whatever `env_en` is, and it takes priority over an expiry in the same cycle.
- R3: With `env_en` held high, the first step comes exactly (interval + 1) × TICK_UNIT clock edges after the start edge, and each later step the same number of edges after the one before it.
- R4: When `env_dir` = 0 (down) and the level is nonzero, an expiry lowers the level by one.
- R5: When `env_dir` = 1 (up) and the level is below 15, an expiry raises the level by one.
- R6: When an expiry finds the level at its limit (0 going down, 15 going up) and `env_rep` = 1, the level is set to `env_reload`.
- R7: When an expiry finds the level at its limit and `env_rep` = 0, the level holds.
- R8: While `env_en` is low, no expiry occurs and the level and the countdown hold. When the enable returns, the countdown continues from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| env_en | input | 1 | Lets the countdown advance |
| env_dir | input | 1 | Step direction: 0 down, 1 up |
| env_rep | input | 1 | At the limit, reload instead of holding |
| env_reload | input | 4 | Start level |
| env_interval | input | INTERVAL_W | Period selector: period = (value + 1) × TICK_UNIT |
| env_start | input | 1 | One-cycle strobe that loads the level and restarts the countdown |
| level | output | 4 | Current envelope level |

## Verification
A corrupted countdown shows at the port as a step that comes early or late against the (interval + 1) × TICK_UNIT period. The first such error is visible within one period of a start strobe. A wrong step decision shows on the very expiry that makes it: the level moves the wrong way, passes a limit, or fails to reload. A countdown that leaks while disabled shows as a step arriving sooner than the cycles spent enabled would allow.

// File: rtl/env_pkg.sv
package env_pkg;
    localparam int LEVEL_W = 4;
    localparam int LEVEL_MAX = (1 << LEVEL_W) - 1;

    typedef logic [LEVEL_W-1:0] level_t;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } env_dir_e;
endpackage

// File: rtl/env_prescaler.sv
module env_prescaler #(
    parameter int TICK_UNIT  = 307220,
    parameter int INTERVAL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  restart,
    input  logic [INTERVAL_W-1:0] interval,
    output logic                  tick
);
    localparam int unsigned MAX_PERIOD = TICK_UNIT * (1 << INTERVAL_W);
    localparam int CNT_W = (MAX_PERIOD > 2) ? $clog2(MAX_PERIOD) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [CNT_W-1:0] period_m1;
    int unsigned      period_full;

    always_comb begin
        period_full = (32'(interval) + 32'd1) * 32'(TICK_UNIT);
        period_m1   = CNT_W'(period_full - 32'd1);
    end

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        if (restart) begin
            s_d.cnt = period_m1;
        end else if (run) begin
            if (s_q.cnt == '0) begin
                tick    = 1'b1;
                s_d.cnt = period_m1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/env_level_step.sv
module env_level_step
    import env_pkg::*;
(
    input  level_t   cur,
    input  env_dir_e dir,
    input  logic     rep,
    input  level_t   reload,
    output level_t   nxt
);
    logic at_limit;

    always_comb begin
        at_limit = (dir == DIR_DOWN) ? (cur == '0) : (cur == level_t'(LEVEL_MAX));
        if (!at_limit) begin
            nxt = (dir == DIR_DOWN) ? cur - 1'b1 : cur + 1'b1;
        end else if (rep) begin
            nxt = reload;
        end else begin
            nxt = cur;
        end
    end
endmodule

// File: rtl/vol_env_gen.sv
module vol_env_gen
    import env_pkg::*;
#(
    parameter int TICK_UNIT  = 307220,
    parameter int INTERVAL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  env_en,
    input  logic                  env_dir,
    input  logic                  env_rep,
    input  logic [3:0]            env_reload,
    input  logic [INTERVAL_W-1:0] env_interval,
    input  logic                  env_start,
    output logic [3:0]            level
);
    typedef struct packed {
        level_t lvl;
    } env_state_t;

    env_state_t st_d, st_q;
    logic       tick;
    level_t     step_lvl;

    env_prescaler #(
        .TICK_UNIT  (TICK_UNIT),
        .INTERVAL_W (INTERVAL_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (env_en),
        .restart  (env_start),
        .interval (env_interval),
        .tick     (tick)
    );

    env_level_step u_step (
        .cur    (st_q.lvl),
        .dir    (env_dir_e'(env_dir)),
        .rep    (env_rep),
        .reload (env_reload),
        .nxt    (step_lvl)
    );

    always_comb begin
        st_d = st_q;
        if (env_start) begin
            st_d.lvl = env_reload;
        end else if (tick) begin
            st_d.lvl = step_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.lvl;
endmodule

// File: rtl/vol_env_gen_checker.sv
module vol_env_gen_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       env_en,
    input logic       env_dir,
    input logic       env_rep,
    input logic [3:0] env_reload,
    input logic       env_start,
    input logic       tick,
    input logic [3:0] level
);
    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        env_start |=> level == $past(env_reload));

    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !env_start && !env_dir && level != 4'd0) |=> level == $past(level) - 4'd1);

    assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !env_start && env_dir && level != 4'd15) |=> level == $past(level) + 4'd1);

    assert_limit_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !env_start && env_rep &&
         ((env_dir && level == 4'd15) || (!env_dir && level == 4'd0)))
        |=> level == $past(env_reload));

    assert_limit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !env_start && !env_rep &&
         ((env_dir && level == 4'd15) || (!env_dir && level == 4'd0)))
        |=> $stable(level));

    assert_tick_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> env_en);

    assert_quiet_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !env_start) |=> $stable(level));
endmodule

bind vol_env_gen vol_env_gen_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .env_en     (env_en),
    .env_dir    (env_dir),
    .env_rep    (env_rep),
    .env_reload (env_reload),
    .env_start  (env_start),
    .tick       (tick),
    .level      (level)
);

// File: tb/vol_env_gen_test.sv
module vol_env_gen_test;
    localparam int UNIT = 3;
    localparam int IW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          env_en = 1'b0;
    logic          env_dir = 1'b0;
    logic          env_rep = 1'b0;
    logic [3:0]    env_reload = '0;
    logic [IW-1:0] env_interval = '0;
    logic          env_start = 1'b0;
    logic [3:0]    level;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];
    event       chk_ev;

    always #4 clk = ~clk;

    vol_env_gen #(.TICK_UNIT(UNIT), .INTERVAL_W(IW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .env_en       (env_en),
        .env_dir      (env_dir),
        .env_rep      (env_rep),
        .env_reload   (env_reload),
        .env_interval (env_interval),
        .env_start    (env_start),
        .level        (level)
    );

    // monitor: pops expected items and compares them with the port
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (level !== e) begin
                    n_bad++;
                    $display("FAIL %s: level actual %0d expected %0d", t, level, e);
                end
            end
        end
    end

    task automatic expect_lvl(input logic [3:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        ->chk_ev;
        #1;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_env(input logic [3:0] rl, input logic d, input logic rp,
                             input logic [IW-1:0] iv, input logic en);
        env_reload   = rl;
        env_dir      = d;
        env_rep      = rp;
        env_interval = iv;
        env_en       = en;
        env_start    = 1'b1;
        cyc(1);
        env_start    = 1'b0;
    endtask

    initial begin
        int p;
        cyc(3);
        rst_n = 1'b1;
        expect_lvl(4'd0, "R1 reset level");

        // down ramp, interval 1 -> period 6
        p = 2 * UNIT;
        start_env(4'd5, 1'b0, 1'b0, 3'd1, 1'b1);
        expect_lvl(4'd5, "R2 start loads reload");
        cyc(p - 1);
        expect_lvl(4'd5, "R3 no step before period");
        cyc(1);
        expect_lvl(4'd4, "R4 first decrement");
        cyc(p);
        expect_lvl(4'd3, "R4 second decrement");
        cyc(3 * p);
        expect_lvl(4'd0, "R4 reaches zero");
        cyc(p);
        expect_lvl(4'd0, "R7 hold at zero");
        env_rep = 1'b1;
        cyc(p);
        expect_lvl(4'd5, "R6 reload at zero");

        // up ramp, interval 0 -> period 3
        p = UNIT;
        start_env(4'd13, 1'b1, 1'b0, 3'd0, 1'b1);
        expect_lvl(4'd13, "R2 start loads 13");
        cyc(p);
        expect_lvl(4'd14, "R5 increment");
        cyc(p);
        expect_lvl(4'd15, "R5 reaches 15");
        cyc(p);
        expect_lvl(4'd15, "R7 hold at 15");
        env_rep = 1'b1;
        cyc(p);
        expect_lvl(4'd13, "R6 reload at 15");

        // freeze while disabled
        start_env(4'd8, 1'b0, 1'b0, 3'd0, 1'b1);
        cyc(1);
        env_en = 1'b0;
        cyc(10);
        expect_lvl(4'd8, "R8 hold while disabled");
        env_en = 1'b1;
        cyc(1);
        expect_lvl(4'd8, "R8 countdown resumes not restarts");
        cyc(1);
        expect_lvl(4'd7, "R8 step after remaining count");

        // start priority over an expiry
        start_env(4'd10, 1'b0, 1'b0, 3'd0, 1'b1);
        cyc(UNIT - 1);
        start_env(4'd3, 1'b0, 1'b0, 3'd0, 1'b1);
        expect_lvl(4'd3, "R2 start wins over expiry");
        cyc(UNIT - 1);
        expect_lvl(4'd3, "R3 period restarted by start");
        cyc(1);
        expect_lvl(4'd2, "R3 step after restarted period");

        // start while disabled
        start_env(4'd9, 1'b1, 1'b0, 3'd0, 1'b0);
        cyc(5);
        expect_lvl(4'd9, "R2 start loads while disabled");

        // longest interval: period 8*UNIT
        p = 8 * UNIT;
        start_env(4'd0, 1'b1, 1'b0, 3'd7, 1'b1);
        cyc(p - 1);
        expect_lvl(4'd0, "R3 long period not early");
        cyc(1);
        expect_lvl(4'd1, "R3 long period step");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule